// File: doc/BRIEF.md
# Sequence-Locked Low-Power Entry Controller

This controller sits between software and the power-management hardware. It lets software put the system into a low-power state only after a fixed pattern of four writes to a single request bit. The values written must be 1, 1, 0, 1, in that order, with no interrupt pending in between. A separate register selects which low-power mode to use. When the pattern completes, the controller decodes that selection and pulses exactly one request line for one clock: stop, software reset, wait-for-interrupt (with flash kept on or switched off) or standby. It then stays in a low-power state until the wake input rises.

After wake-up, software reads two bits to learn what happened. The request bit reads back as 0 once an attempt has been processed. The sticky done flag is 1 only if entry actually took place, and it stays set until software writes 0 to it. An aborted attempt leaves the done flag at 0, and software must start the pattern again from the first write.

Top module: `lp_entry_ctrl`

## Requirements
- R1: The controller enters low power when four consecutive LP writes (CTRL register, address 0, bit 0) carry the values 1, 1, 0, 1. The request pulse and the done flag appear in the cycle after the edge that takes the fourth write.
- R2: An LP write that breaks the expected order sends the tracker back to idle. A 1 written at that point counts as the first step of a new pattern, so 1,1,1,1,0,1 enters and 1,1,1,0,1 does not.
- R3: An interrupt pending at any clock edge outside the low-power state clears LP to 0 and sends the tracker back to idle. This includes an edge that also takes the fourth write. No entry follows, and a complete new pattern is needed.
- R4: Read address 0 bit 0 gives the LP value. It holds the last value written while a pattern is in progress, and it reads 0 after completion or an abort. Reset clears all registers to 0.
- R5: The done flag (STATUS register, address 2, bit 0) is set only on entry. Writing 0 to it clears it, and writing 1 to it has no effect.
- R6: The mode field (MODE register, address 1, bits [1:0]) selects the request output: 00 stop, 01 software reset, 10 wait-for-interrupt, 11 standby. Exactly one request output is high, and only for one clock.
- R7: In wait-for-interrupt mode, `wfi_flash_keep` is 1 from entry until wake when MODE bit 3 (flash enable) is 1. It is 0 when MODE bits 3 and 2 (burst) are both 0.
- R8: Mode 10 with burst=1 and flash enable=0 is forbidden. Completing the pattern with that setting gives no request, leaves done at 0 and clears LP.
- R9: After entry, `lp_active` stays high until `wake` is high at a clock edge. LP writes made while it is high are ignored.
- R10: Writes to MODE or STATUS during a pattern do not change the progress of the tracker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | AW | Read address |
| rd_data | output | DW | Registered read data, valid the cycle after rd_en |
| irq_pending | input | 1 | An interrupt is waiting to be served |
| wake | input | 1 | Wake event that ends the low-power state |
| req_stop | output | 1 | One-cycle stop-mode request |
| req_swreset | output | 1 | One-cycle software-reset request |
| req_wfi | output | 1 | One-cycle wait-for-interrupt request |
| req_standby | output | 1 | One-cycle standby request |
| wfi_flash_keep | output | 1 | Flash stays powered during this wait-for-interrupt period |
| lp_active | output | 1 | Low-power state held until wake |

## Verification
On every cycle, the assertions check the following:
- At most one request line is high, and no request lasts longer than one cycle.
- The low-power state holds until wake.
- A wait-for-interrupt request never follows the forbidden setting.
- The done flag rises only together with a request.
- LP reads 0 whenever a request fires.
- A pending interrupt always returns the tracker to idle.

Other behaviour can only be shown by the bench scenarios. These cover which write orders lead to entry, including a broken order that restarts on a 1, and an interrupt that arrives on the same edge as the final write. They also cover ignored writes while asleep, the effect of writing 1 versus 0 to the done flag, and the read-back values before and after an attempt.

// File: rtl/lpe_pkg.sv
package lpe_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ONE   = 2'd1,
    SEQ_TWO   = 2'd2,
    SEQ_THREE = 2'd3
  } seq_state_t;

  localparam int unsigned REG_CTRL   = 0;
  localparam int unsigned REG_MODE   = 1;
  localparam int unsigned REG_STATUS = 2;

  localparam int unsigned MODE_W  = 4;
  localparam int unsigned SEL_W   = 2;
  localparam int unsigned N_MODES = 1 << SEL_W;
  localparam int unsigned WFI_SEL = 2;

endpackage

// File: rtl/lpe_seq_tracker.sv
module lpe_seq_tracker
  import lpe_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic hold,
  input  logic lp_wr,
  input  logic lp_val,
  input  logic irq,
  output logic fire
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d = state_q;
    fire    = 1'b0;
    if (hold) begin
      state_d = SEQ_IDLE;
    end else if (irq) begin
      state_d = SEQ_IDLE;
    end else if (lp_wr) begin
      unique case (state_q)
        SEQ_IDLE:  state_d = lp_val ? SEQ_ONE : SEQ_IDLE;
        SEQ_ONE:   state_d = lp_val ? SEQ_TWO : SEQ_IDLE;
        SEQ_TWO:   state_d = lp_val ? SEQ_ONE : SEQ_THREE;
        SEQ_THREE: begin
          state_d = SEQ_IDLE;
          fire    = lp_val;
        end
        default:   state_d = SEQ_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= SEQ_IDLE;
    else     state_q <= state_d;
  end

  // R3: a pending interrupt always leaves the tracker idle
  a_r3_irq_to_idle: assert property (@(posedge clk) disable iff (rst)
    (irq && !hold) |=> (state_q == SEQ_IDLE));

  // R1: completion only from the third step
  a_r1_fire_after_three: assert property (@(posedge clk) disable iff (rst)
    fire |-> (state_q == SEQ_THREE));

endmodule

// File: rtl/lpe_mode_decode.sv
module lpe_mode_decode
  import lpe_pkg::*;
(
  input  logic [SEL_W-1:0]   sel,
  input  logic               burst,
  input  logic               flash_en,
  output logic [N_MODES-1:0] req_vec,
  output logic               keep_flash,
  output logic               legal
);

  logic is_wfi;

  assign is_wfi     = (sel == SEL_W'(WFI_SEL));
  assign legal      = !(is_wfi && burst && !flash_en);
  assign keep_flash = is_wfi && flash_en;

  for (genvar m = 0; m < N_MODES; m++) begin : g_sel
    assign req_vec[m] = legal && (sel == SEL_W'(m));
  end

endmodule

// File: rtl/lp_entry_ctrl.sv
module lp_entry_ctrl
  import lpe_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          irq_pending,
  input  logic          wake,
  output logic          req_stop,
  output logic          req_swreset,
  output logic          req_wfi,
  output logic          req_standby,
  output logic          wfi_flash_keep,
  output logic          lp_active
);

  localparam int BURST_BIT = SEL_W;
  localparam int FLASH_BIT = SEL_W + 1;

  logic               lp_q, done_q, asleep_q, keep_q;
  logic [MODE_W-1:0]  mode_q;
  logic [N_MODES-1:0] req_q, dec_req;
  logic               dec_keep, dec_legal, fire;
  logic               wr_ctrl, wr_mode, wr_status;

  assign wr_ctrl   = wr_en && (wr_addr == AW'(REG_CTRL));
  assign wr_mode   = wr_en && (wr_addr == AW'(REG_MODE));
  assign wr_status = wr_en && (wr_addr == AW'(REG_STATUS));

  lpe_seq_tracker u_track (
    .clk    (clk),
    .rst    (rst),
    .hold   (asleep_q),
    .lp_wr  (wr_ctrl),
    .lp_val (wr_data[0]),
    .irq    (irq_pending),
    .fire   (fire)
  );

  lpe_mode_decode u_dec (
    .sel        (mode_q[SEL_W-1:0]),
    .burst      (mode_q[BURST_BIT]),
    .flash_en   (mode_q[FLASH_BIT]),
    .req_vec    (dec_req),
    .keep_flash (dec_keep),
    .legal      (dec_legal)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lp_q     <= 1'b0;
      done_q   <= 1'b0;
      asleep_q <= 1'b0;
      keep_q   <= 1'b0;
      req_q    <= '0;
    end else begin
      req_q <= '0;
      if (!asleep_q) begin
        if (fire) begin
          lp_q <= 1'b0;
          if (dec_legal) begin
            req_q    <= dec_req;
            keep_q   <= dec_keep;
            done_q   <= 1'b1;
            asleep_q <= 1'b1;
          end
        end else if (irq_pending) begin
          lp_q <= 1'b0;
        end else if (wr_ctrl) begin
          lp_q <= wr_data[0];
        end
      end else if (wake) begin
        asleep_q <= 1'b0;
        keep_q   <= 1'b0;
      end
      if (wr_status && !wr_data[0]) done_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) mode_q <= '0;
    else if (wr_mode) mode_q <= wr_data[MODE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_addr == AW'(REG_CTRL))        rd_data <= DW'(lp_q);
      else if (rd_addr == AW'(REG_MODE))   rd_data <= DW'(mode_q);
      else if (rd_addr == AW'(REG_STATUS)) rd_data <= DW'(done_q);
      else                                 rd_data <= '0;
    end
  end

  assign req_stop       = req_q[0];
  assign req_swreset    = req_q[1];
  assign req_wfi        = req_q[2];
  assign req_standby    = req_q[3];
  assign wfi_flash_keep = keep_q;
  assign lp_active      = asleep_q;

  // R6: never more than one request line
  a_r6_one_request: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_standby, req_wfi, req_swreset, req_stop}));

  // R6: requests last one clock
  a_r6_single_cycle: assert property (@(posedge clk) disable iff (rst)
    (req_stop || req_swreset || req_wfi || req_standby) |=>
    !(req_stop || req_swreset || req_wfi || req_standby));

  // R9: low-power state held until wake
  a_r9_hold_until_wake: assert property (@(posedge clk) disable iff (rst)
    (lp_active && !wake) |=> lp_active);

  // R8: no wait request after the forbidden setting
  a_r8_no_forbidden: assert property (@(posedge clk) disable iff (rst)
    req_wfi |-> !($past(mode_q[BURST_BIT]) && !$past(mode_q[FLASH_BIT])));

  // R5: done rises only with an entry request
  a_r5_done_with_req: assert property (@(posedge clk) disable iff (rst)
    $rose(done_q) |-> (req_stop || req_swreset || req_wfi || req_standby));

  // R4: LP reads zero once entry happens
  a_r4_lp_clear_on_entry: assert property (@(posedge clk) disable iff (rst)
    (req_stop || req_swreset || req_wfi || req_standby) |-> !lp_q);

endmodule

// File: tb/test_lp_entry_ctrl.sv
`timescale 1ns/1ps
module test_lp_entry_ctrl;

  localparam int AW = 2;
  localparam int DW = 8;

  typedef struct packed {
    logic [3:0] mode;
    logic [2:0] nw;
    logic [5:0] w;
    logic [2:0] irq_at;
    logic       exp_done;
    logic [3:0] exp_req;
    logic       exp_keep;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{4'b0000, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b0001, 1'b0},
    '{4'b0001, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b0010, 1'b0},
    '{4'b0010, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b0100, 1'b0},
    '{4'b1010, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b0100, 1'b1},
    '{4'b1110, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b0100, 1'b1},
    '{4'b0011, 3'd4, 6'b001011, 3'd7, 1'b1, 4'b1000, 1'b0},
    '{4'b0110, 3'd4, 6'b001011, 3'd7, 1'b0, 4'b0000, 1'b0},
    '{4'b0000, 3'd5, 6'b010111, 3'd7, 1'b0, 4'b0000, 1'b0},
    '{4'b0000, 3'd6, 6'b101111, 3'd7, 1'b1, 4'b0001, 1'b0},
    '{4'b0000, 3'd4, 6'b001011, 3'd2, 1'b0, 4'b0000, 1'b0},
    '{4'b0000, 3'd4, 6'b001011, 3'd0, 1'b1, 4'b0001, 1'b0},
    '{4'b0011, 3'd5, 6'b010110, 3'd7, 1'b1, 4'b1000, 1'b0},
    '{4'b0001, 3'd6, 6'b101101, 3'd7, 1'b1, 4'b0010, 1'b0}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic          irq_pending = 1'b0;
  logic          wake = 1'b0;
  logic          req_stop, req_swreset, req_wfi, req_standby;
  logic          wfi_flash_keep, lp_active;

  int   n_checks = 0;
  int   n_fail = 0;
  logic [3:0] seen_req = '0;
  int   pulse_cycles = 0;
  logic [DW-1:0] rv;

  always #2.5 clk = ~clk;

  lp_entry_ctrl #(.AW(AW), .DW(DW)) i_lp_entry_ctrl (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .irq_pending(irq_pending), .wake(wake),
    .req_stop(req_stop), .req_swreset(req_swreset), .req_wfi(req_wfi),
    .req_standby(req_standby), .wfi_flash_keep(wfi_flash_keep), .lp_active(lp_active)
  );

  always @(negedge clk) begin
    if (req_stop || req_swreset || req_wfi || req_standby) begin
      seen_req     <= seen_req | {req_standby, req_wfi, req_swreset, req_stop};
      pulse_cycles <= pulse_cycles + 1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk); rst = 1'b0;
    seen_req = '0; pulse_cycles = 0;
  endtask

  task automatic wr(input int a, input int d, input bit with_irq);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = DW'(d); irq_pending = with_irq;
    @(negedge clk);
    wr_en = 1'b0; irq_pending = 1'b0;
  endtask

  task automatic rd(input int a, output logic [DW-1:0] v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = AW'(a);
    @(negedge clk);
    rd_en = 1'b0; v = rd_data;
  endtask

  task automatic irq_pulse();
    @(negedge clk); irq_pending = 1'b1;
    @(negedge clk); irq_pending = 1'b0;
  endtask

  task automatic wake_pulse();
    @(negedge clk); wake = 1'b1;
    @(negedge clk); wake = 1'b0;
  endtask

  task automatic seq_1101();
    wr(0, 1, 1'b0); wr(0, 1, 1'b0); wr(0, 0, 1'b0); wr(0, 1, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    do_reset();
    // R4: reset state
    check(lp_active == 1'b0, "R4 reset lp_active", lp_active, 0);
    check({req_standby, req_wfi, req_swreset, req_stop} == 4'b0, "R4 reset requests",
          {req_standby, req_wfi, req_swreset, req_stop}, 0);
    rd(0, rv); check(rv == 0, "R4 reset CTRL", rv, 0);
    rd(2, rv); check(rv == 0, "R4 reset STATUS", rv, 0);

    // Vector table: R1 R2 R3 R6 R7 R8
    for (int v = 0; v < NV; v++) begin
      do_reset();
      wr(1, VECS[v].mode, 1'b0);
      for (int i = 0; i < 6; i++) begin
        if (i < VECS[v].nw) begin
          if (VECS[v].irq_at == i) irq_pulse();
          wr(0, VECS[v].w[i], 1'b0);
        end
      end
      @(negedge clk); @(negedge clk);
      rd(2, rv);
      check(rv[0] == VECS[v].exp_done, $sformatf("R1/R2/R3/R8 vec%0d done", v), rv[0], VECS[v].exp_done);
      check(seen_req == VECS[v].exp_req, $sformatf("R6 vec%0d request", v), seen_req, VECS[v].exp_req);
      check(pulse_cycles == int'(VECS[v].exp_done), $sformatf("R6 vec%0d pulse width", v),
            pulse_cycles, int'(VECS[v].exp_done));
      check(wfi_flash_keep == VECS[v].exp_keep, $sformatf("R7 vec%0d flash keep", v),
            wfi_flash_keep, VECS[v].exp_keep);
      check(lp_active == VECS[v].exp_done, $sformatf("R9 vec%0d lp_active", v), lp_active, VECS[v].exp_done);
      if (VECS[v].exp_done) begin
        wake_pulse();
        check(lp_active == 1'b0, $sformatf("R9 vec%0d wake", v), lp_active, 0);
        check(wfi_flash_keep == 1'b0, $sformatf("R7 vec%0d keep after wake", v), wfi_flash_keep, 0);
      end
    end

    // R4 and R10: read-back mid sequence, MODE/STATUS writes interleaved
    do_reset();
    wr(1, 4'b0000, 1'b0);
    wr(0, 1, 1'b0);
    rd(0, rv); check(rv == 1, "R4 LP during pattern", rv, 1);
    wr(1, 4'b0011, 1'b0);
    wr(0, 1, 1'b0);
    wr(2, 0, 1'b0);
    wr(0, 0, 1'b0);
    wr(0, 1, 1'b0);
    @(negedge clk);
    check(seen_req == 4'b1000, "R10 interleaved writes entry", seen_req, 4'b1000);
    rd(0, rv); check(rv == 0, "R4 LP after entry", rv, 0);
    rd(2, rv); check(rv == 1, "R5 done after entry", rv, 1);

    // R9: LP writes ignored while asleep
    wr(0, 1, 1'b0);
    rd(0, rv); check(rv == 0, "R9 LP write ignored asleep", rv, 0);
    repeat (5) @(negedge clk);
    check(lp_active == 1'b1, "R9 still asleep", lp_active, 1);
    wake_pulse();
    check(lp_active == 1'b0, "R9 woke", lp_active, 0);

    // R5: write 1 no effect, write 0 clears
    wr(2, 1, 1'b0);
    rd(2, rv); check(rv == 1, "R5 write 1 keeps done", rv, 1);
    wr(2, 0, 1'b0);
    rd(2, rv); check(rv == 0, "R5 write 0 clears done", rv, 0);

    // R3: interrupt mid-pattern clears LP
    do_reset();
    wr(0, 1, 1'b0);
    irq_pulse();
    rd(0, rv); check(rv == 0, "R3 LP cleared by irq", rv, 0);

    // R3: interrupt on the final write's edge, then full restart
    do_reset();
    wr(0, 1, 1'b0); wr(0, 1, 1'b0); wr(0, 0, 1'b0); wr(0, 1, 1'b1);
    @(negedge clk);
    check(seen_req == 4'b0, "R3 irq with final write", seen_req, 0);
    rd(2, rv); check(rv == 0, "R3 no done after abort", rv, 0);
    rd(0, rv); check(rv == 0, "R3 LP zero after abort", rv, 0);
    wr(0, 1, 1'b0);
    check(lp_active == 1'b0, "R3 single write no entry", lp_active, 0);
    wr(0, 0, 1'b0);
    seq_1101();
    @(negedge clk);
    check(seen_req == 4'b0001, "R3 restart enters", seen_req, 4'b0001);

    // R8: forbidden setting clears LP
    do_reset();
    wr(1, 4'b0110, 1'b0);
    seq_1101();
    rd(0, rv); check(rv == 0, "R8 LP cleared forbidden", rv, 0);
    check(lp_active == 1'b0, "R8 no low power", lp_active, 0);

    summary();
  end

endmodule